// File: doc/BRIEF.md
# Pulse-Width Return-to-Zero Downlink Modulator

This block turns a slow serial bitstream into return-to-zero pulse-width symbols that switch a carrier oscillator on and off. A bit period is a runtime number of clock ticks, counted by an internal timer. Every symbol opens with the carrier switched on. A zero keeps the carrier on for a quarter of the period and a one keeps it on for three quarters; the rest of the period is off. Every bit therefore carries a rising edge that the far end can use as a clock, and its data is read from the pulse width.

Bits arrive over a valid/ready handshake. A bit is taken only at a bit boundary: when the modulator is idle, or on the final tick of the bit being sent, so that bits can follow one another with no gap. Sending is allowed only while the transmit-mode flag is high, because the link carries one direction at a time. A bit already under way always completes, even if the flag falls partway through. The period length and the data value are captured when the bit is accepted. Changes to those inputs later in the bit have no effect on it.

Top module: `pwm_downlink_mod`

## Requirements
- R1: After reset `carrier_en` is low, and `bit_ready` equals `tx_mode` until a bit is accepted.
- R2: A bit with `bit_data` = 0 drives `carrier_en` high for the first P/4 ticks of its period and low for the remaining 3P/4, where P is `ticks_per_bit` at acceptance.
- R3: A bit with `bit_data` = 1 drives `carrier_en` high for the first 3P/4 ticks and low for the last P/4.
- R4: Each bit lasts exactly P ticks. `carrier_en` rises in the cycle after the accepting clock edge, and it is low on the last tick of every bit, so bits sent back to back each begin with a rising edge.
- R5: `carrier_en` stays low whenever no bit is in progress, whether `bit_valid` is low or `tx_mode` is low.
- R6: `bit_ready` is high only while `tx_mode` is high and the block is idle or on the last tick of a bit. A bit is accepted on a clock edge where `bit_valid` and `bit_ready` are both high.
- R7: If `tx_mode` falls during a bit, that bit completes with its full waveform. After it, no further bit is accepted and `carrier_en` stays low.
- R8: `ticks_per_bit` is sampled only at acceptance. Changing it during a bit does not alter that bit's timing.
- R9: `bit_data` is sampled only at acceptance. Changing it during a bit does not alter that bit's pulse width.
- R10: `ticks_per_bit` must be a multiple of 4 and at least 4 whenever a bit is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 1 | High while the link is in its sending direction |
| ticks_per_bit | input | CNT_W | Bit period in ticks (multiple of 4, at least 4) |
| bit_valid | input | 1 | A bit is offered on `bit_data` |
| bit_data | input | 1 | Value of the offered bit |
| bit_ready | output | 1 | The block takes the offered bit on this edge |
| carrier_en | output | 1 | On-off keying enable for the carrier oscillator |

## Verification
The hardest case to reach is a boundary where the last tick of one bit and the acceptance of the next fall in the same cycle. There, the gap of a single low tick is the only thing that produces the next rising edge. The stimulus raises `bit_valid` with fresh data exactly on that final tick over random streams of random period lengths. In the same runs, it scrambles `ticks_per_bit` and `bit_data` in the middle of each bit. A separate directed case drops `tx_mode` inside a bit while a further bit is still being offered, to confirm that the current bit completes and the offered bit is refused.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
   typedef enum logic {
      SYM_ZERO = 1'b0,
      SYM_ONE  = 1'b1
   } sym_e;

   localparam int MIN_TICKS = 4;
endpackage

// File: rtl/pdm_handshake.sv
module pdm_handshake
   import pdm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tx_mode,
   input  logic bit_valid,
   input  logic bit_data,
   input  logic last_tick,
   output logic bit_ready,
   output logic accept,
   output logic busy,
   output sym_e sym
);
   assign bit_ready = tx_mode && (!busy || last_tick);
   assign accept    = bit_ready && bit_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sym  <= SYM_ZERO;
      end else begin
         if (accept) begin
            busy <= 1'b1;
            sym  <= bit_data ? SYM_ONE : SYM_ZERO;
         end else if (last_tick) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pdm_bit_timer.sv
module pdm_bit_timer #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [CNT_W-1:0] period_in,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] period_q,
   output logic             last_tick
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign last_tick = run && (cnt == period_q - ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         period_q <= '0;
      end else if (start) begin
         cnt      <= '0;
         period_q <= period_in;
      end else if (run && !last_tick) begin
         cnt <= cnt + ONE;
      end
   end
endmodule

// File: rtl/pdm_shaper.sv
module pdm_shaper
   import pdm_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             busy,
   input  sym_e             sym,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] period_q,
   output logic             pulse_on
);
   logic [CNT_W-1:0] quarter;
   logic [CNT_W-1:0] high_len;

   always_comb begin
      quarter  = period_q >> 2;
      high_len = (sym == SYM_ONE) ? (period_q - quarter) : quarter;
      pulse_on = busy && (cnt < high_len);
   end
endmodule

// File: rtl/pwm_downlink_mod.sv
module pwm_downlink_mod
   import pdm_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int OUT_REG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_mode,
   input  logic [CNT_W-1:0] ticks_per_bit,
   input  logic             bit_valid,
   input  logic             bit_data,
   output logic             bit_ready,
   output logic             carrier_en
);
   generate
      if (CNT_W < 3) begin : g_bad_width
         $error("pwm_downlink_mod: CNT_W must be at least 3");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
         $error("pwm_downlink_mod: OUT_REG must be 0 or 1");
      end
   endgenerate

   logic             accept;
   logic             busy;
   logic             last_tick;
   sym_e             sym;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] period_q;
   logic             pulse_on;

   pdm_handshake u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_mode   (tx_mode),
      .bit_valid (bit_valid),
      .bit_data  (bit_data),
      .last_tick (last_tick),
      .bit_ready (bit_ready),
      .accept    (accept),
      .busy      (busy),
      .sym       (sym)
   );

   pdm_bit_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .run       (busy),
      .period_in (ticks_per_bit),
      .cnt       (cnt),
      .period_q  (period_q),
      .last_tick (last_tick)
   );

   pdm_shaper #(.CNT_W(CNT_W)) u_shape (
      .busy     (busy),
      .sym      (sym),
      .cnt      (cnt),
      .period_q (period_q),
      .pulse_on (pulse_on)
   );

   generate
      if (OUT_REG == 1) begin : g_out_flop
         logic en_q;
         always_ff @(posedge clk) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= pulse_on;
         end
         assign carrier_en = en_q;
      end else begin : g_out_comb
         assign carrier_en = pulse_on;
      end
   endgenerate
endmodule

// File: rtl/pdm_checker.sv
module pdm_checker #(
   parameter int CNT_W   = 10,
   parameter int OUT_REG = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_mode,
   input logic [CNT_W-1:0] ticks_per_bit,
   input logic             bit_valid,
   input logic             bit_ready,
   input logic             carrier_en,
   input logic             busy,
   input logic             last_tick,
   input logic [CNT_W-1:0] period_q
);
   assert_ready_needs_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_ready |-> tx_mode);

   assert_legal_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && bit_ready) |-> (ticks_per_bit[1:0] == 2'b00 && ticks_per_bit >= CNT_W'(4)));

   assert_bit_runs_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last_tick) |=> busy);

   assert_period_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last_tick) |=> $stable(period_q));

   generate
      if (OUT_REG == 1) begin : g_lat1
         assert_accept_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_valid && bit_ready) |=> ##1 carrier_en);
         assert_last_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            last_tick |=> !carrier_en);
         assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !busy |=> !carrier_en);
      end else begin : g_lat0
         assert_accept_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_valid && bit_ready) |=> carrier_en);
         assert_last_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            last_tick |-> !carrier_en);
         assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !busy |-> !carrier_en);
      end
   endgenerate
endmodule

bind pwm_downlink_mod pdm_checker #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_pdm_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_mode       (tx_mode),
   .ticks_per_bit (ticks_per_bit),
   .bit_valid     (bit_valid),
   .bit_ready     (bit_ready),
   .carrier_en    (carrier_en),
   .busy          (busy),
   .last_tick     (last_tick),
   .period_q      (period_q)
);

// File: tb/tb_pwm_downlink_mod.sv
`timescale 1ns/1ps
module tb_pwm_downlink_mod;
   localparam int CNT_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tx_mode = 1'b0;
   logic [CNT_W-1:0] ticks_per_bit = '0;
   logic             bit_valid = 1'b0;
   logic             bit_data = 1'b0;
   logic             bit_ready;
   logic             carrier_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwm_downlink_mod #(.CNT_W(CNT_W), .OUT_REG(0)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tx_mode       (tx_mode),
      .ticks_per_bit (ticks_per_bit),
      .bit_valid     (bit_valid),
      .bit_data      (bit_data),
      .bit_ready     (bit_ready),
      .carrier_en    (carrier_en)
   );

   function automatic int high_len(input bit d, input int p);
      return d ? (p - p / 4) : (p / 4);
   endfunction

   function automatic int rand_period();
      return 4 * (1 + int'($urandom % 16));
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Send n bits of period p back to back. drop_at >= 0 lowers tx_mode at that tick
   // of the first bit and keeps offering a bit; scramble changes inputs mid-bit.
   task automatic run_stream(input int n, input int p, input int drop_at, input bit scramble);
      bit cur, nxt;
      int hi;
      @(negedge clk);
      ticks_per_bit = CNT_W'(p);
      cur = 1'($urandom);
      bit_data = cur;
      bit_valid = 1'b1;
      #1;
      chk(bit_ready == 1'b1, "R6 ready at idle", int'(bit_ready), 1);
      for (int i = 0; i < n; i++) begin
         nxt = 1'($urandom);
         hi = high_len(cur, p);
         @(posedge clk);
         for (int k = 0; k < p; k++) begin
            @(negedge clk);
            if (k == 0 && drop_at < 0) bit_valid = 1'b0;
            if (k == drop_at) tx_mode = 1'b0;
            if (scramble && k == 1) begin
               ticks_per_bit = CNT_W'($urandom);
               bit_data = ~cur;
            end
            if (k == p - 1 && i < n - 1) begin
               bit_valid = 1'b1;
               ticks_per_bit = CNT_W'(p);
               bit_data = nxt;
            end
            #1;
            if (cur)
               chk(carrier_en == (k < hi), scramble ? "R3/R8/R9 one pulse" : "R3 one pulse",
                   int'(carrier_en), int'(k < hi));
            else
               chk(carrier_en == (k < hi), scramble ? "R2/R8/R9 zero pulse" : "R2 zero pulse",
                   int'(carrier_en), int'(k < hi));
            if (k == p - 1)
               chk(bit_ready == tx_mode, "R4/R6 ready at boundary", int'(bit_ready), int'(tx_mode));
            else
               chk(bit_ready == 1'b0, "R6 no ready mid-bit", int'(bit_ready), 0);
         end
         cur = nxt;
      end
   endtask

   task automatic idle_check(input int cycles, input string req);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         #1;
         chk(carrier_en == 1'b0, req, int'(carrier_en), 0);
         chk(bit_ready == tx_mode, req, int'(bit_ready), int'(tx_mode));
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(carrier_en == 1'b0, "R1 reset carrier", int'(carrier_en), 0);
      chk(bit_ready == 1'b0, "R1 reset ready", int'(bit_ready), 0);
      rst_n = 1'b1;
      idle_check(3, "R1 idle after reset");

      // R5: valid offered with tx_mode low is refused
      @(negedge clk);
      bit_valid = 1'b1;
      bit_data = 1'b1;
      ticks_per_bit = CNT_W'(8);
      idle_check(6, "R5 tx_mode low");
      bit_valid = 1'b0;

      tx_mode = 1'b1;
      idle_check(3, "R5 no valid");

      // directed minimum period and plain streams
      run_stream(3, 4, -1, 1'b0);
      idle_check(4, "R5 idle after stream");
      run_stream(4, 16, -1, 1'b0);
      idle_check(2, "R5 idle after stream");

      // R7: tx_mode falls mid-bit while another bit is offered
      run_stream(1, 16, 3, 1'b0);
      idle_check(8, "R7 no accept after drop");
      bit_valid = 1'b0;
      tx_mode = 1'b1;

      // random streams with mid-bit scrambling (R8, R9) and back-to-back boundaries (R4)
      for (int r = 0; r < 20; r++) begin
         run_stream(1 + int'($urandom % 6), rand_period(), -1, 1'b1);
         idle_check(int'($urandom % 3), "R5 idle gap");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule